// File: doc/BRIEF.md
# Phase-Offset PWM Generator

This block drives one pulse-width-modulated output. A simple synchronous register port writes a period, a high-time and a start offset, all counted in clock cycles. Within each period the output goes high at the chosen offset and stays high for the chosen number of cycles. The channel runs either without end or for a set number of periods. In the second case it stops by itself and raises an interrupt.

Software writes new settings into staging registers. Nothing reaches the running waveform until a commit bit is written to the enable register. The staged values are then taken over only at the next period boundary, so a period never mixes old and new settings. The enable register is written through a mask in its upper half: a write changes only those enable bits whose mask bit is also set. Turning the channel off stops the cycle counter, and the pin keeps the last level it drove.

Top module: `pwm_offset_gen`

## Requirements
- R1: After reset, `pwm_o` and `irq_o` are 0 and every readable register reads 0.
- R2: While the channel runs with active period P, high-time D and offset O, the cycle counter steps through 0..P-1. The output is registered, so one cycle after the counter holds value c, `pwm_o` is 1 exactly when O <= c < O+D.
- R3: A high-time equal to the period gives a constant high output. A high-time of 0 gives a constant low output.
- R4: When staged values are taken over, a high-time larger than the period is limited to the period. An offset larger than period minus high-time is limited to period minus high-time.
- R5: An active period of 0 keeps the counter and the output frozen. The effective offset and high-time are then 0.
- R6: Writes to period (address 1), high-time (address 2), offset (address 3) or control (address 4) do not change the output until a commit is written.
- R7: A commit is a write to address 0 with bits 2 and 18 both set. It sets a pending flag, read back at address 0 bit 2. While the counter runs, the staged values load when the counter wraps from P-1 to 0. While the counter is not running, they load on the next cycle and the counter restarts at 0. The pending flag clears when the values load.
- R8: Address 0 bit 0 is channel enable and bit 1 is clock enable. A write to address 0 changes bit i (i = 0, 1) only if bit 16+i of the written data is 1. Both bits read back at address 0 bits 1:0.
- R9: While either enable bit is 0, the counter and `pwm_o` hold their values. Setting both bits again resumes from the held count.
- R10: Control bit 0 selects one-shot mode (1) or continuous mode (0). Control bits 8 and up hold a repeat value N. A committed one-shot run lasts N+1 periods. At its last wrap the channel-enable bit clears and `irq_o` rises. Writing 1 to address 5 bit 0 clears `irq_o`. Address 5 bit 0 reads the interrupt flag.
- R11: In continuous mode the channel runs without end and never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_o | output | 1 | PWM output pin |
| irq_o | output | 1 | One-shot completion interrupt |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit repeat field. With these widths, periods of a few to about twenty cycles cover many full periods in a short run. One-shot runs of several periods finish in a few dozen cycles. Random settings often hit the limit cases: zero period, high-time above the period, and offsets past period minus high-time. These cases are checked against a cycle model in the bench, together with commits made while the counter runs.

// File: rtl/pwm_offset_gen.sv
module pwm_offset_gen #(
  parameter int CNT_W = 32,
  parameter int RPT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pwm_o,
  output logic        irq_o
);
  localparam logic [2:0] A_EN = 3'd0, A_PER = 3'd1, A_DUTY = 3'd2,
                         A_OFF = 3'd3, A_CTRL = 3'd4, A_STAT = 3'd5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] per_s, dut_s, off_s, per_a, dut_a, off_a, cnt_q;
  logic [CNT_W-1:0] dut_c, off_c, slack;
  logic [RPT_W-1:0] rpt_s, rpt_q;
  logic [1:0]       en_q;
  logic             mode_s, mode_a, pend_q, done_q, pwm_q;
  logic             run, wrap, load, hi, commit;

  assign dut_c  = (dut_s > per_s) ? per_s : dut_s;
  assign slack  = per_s - dut_c;
  assign off_c  = (per_s == '0) ? '0 : ((off_s > slack) ? slack : off_s);
  assign run    = en_q[0] & en_q[1] & (per_a != '0);
  assign wrap   = run && (cnt_q == per_a - ONE);
  assign load   = pend_q && (wrap || !run);
  assign hi     = (cnt_q >= off_a) && ((cnt_q - off_a) < dut_a);
  assign commit = wr_en && (addr == A_EN) && wdata[2] && wdata[18];
  assign pwm_o  = pwm_q;
  assign irq_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_s <= '0; dut_s <= '0; off_s <= '0; mode_s <= 1'b0; rpt_s <= '0;
      per_a <= '0; dut_a <= '0; off_a <= '0; mode_a <= 1'b0; rpt_q <= '0;
      cnt_q <= '0; en_q <= '0; pend_q <= 1'b0; done_q <= 1'b0; pwm_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_EN: begin
            for (int i = 0; i < 2; i++)
              if (wdata[16+i]) en_q[i] <= wdata[i];
          end
          A_PER:  per_s <= wdata[CNT_W-1:0];
          A_DUTY: dut_s <= wdata[CNT_W-1:0];
          A_OFF:  off_s <= wdata[CNT_W-1:0];
          A_CTRL: begin
            mode_s <= wdata[0];
            rpt_s  <= wdata[8 +: RPT_W];
          end
          A_STAT: if (wdata[0]) done_q <= 1'b0;
          default: ;
        endcase
      end

      if (load) begin
        per_a  <= per_s;
        dut_a  <= dut_c;
        off_a  <= off_c;
        mode_a <= mode_s;
        rpt_q  <= rpt_s;
        cnt_q  <= '0;
      end else if (wrap) begin
        cnt_q <= '0;
        if (mode_a) begin
          if (rpt_q == '0) begin
            en_q[0] <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            rpt_q <= rpt_q - 1'b1;
          end
        end
      end else if (run) begin
        cnt_q <= cnt_q + ONE;
      end

      if (commit)    pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;

      if (run) pwm_q <= hi;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:   rdata[2:0] = {pend_q, en_q};
      A_PER:  rdata[CNT_W-1:0] = per_s;
      A_DUTY: rdata[CNT_W-1:0] = dut_s;
      A_OFF:  rdata[CNT_W-1:0] = off_s;
      A_CTRL: begin
        rdata[0] = mode_s;
        rdata[8 +: RPT_W] = rpt_s;
      end
      A_STAT: rdata[0] = done_q;
      default: ;
    endcase
  end

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> ($stable(cnt_q) && $stable(pwm_o)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < per_a));

  // R4
  off_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_a != '0) |-> (({1'b0, off_a} + {1'b0, dut_a}) <= {1'b0, per_a}));

  // R5
  zero_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_a == '0) |-> ((off_a == '0) && (dut_a == '0)));

  // R10
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> !en_q[0]);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && run && !wrap) |=> pend_q);
endmodule

// File: tb/pwm_offset_gen_tb.sv
`timescale 1ns/1ps
module pwm_offset_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_o, irq_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  string ph = "R1";

  pwm_offset_gen #(.CNT_W(8), .RPT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_o(pwm_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle model built from the requirements
  int m_per_s, m_dut_s, m_off_s, m_mode_s, m_rpt_s;
  int m_per, m_dut, m_off, m_mode, m_rpt, m_cnt;
  int m_en0, m_en1, m_pend, m_done, m_out;
  int r_run, r_wrap, r_load, r_fin, r_com, dc, oc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per_s = 0; m_dut_s = 0; m_off_s = 0; m_mode_s = 0; m_rpt_s = 0;
      m_per = 0; m_dut = 0; m_off = 0; m_mode = 0; m_rpt = 0; m_cnt = 0;
      m_en0 = 0; m_en1 = 0; m_pend = 0; m_done = 0; m_out = 0;
    end else begin
      r_run  = (m_en0 && m_en1 && m_per != 0);
      r_wrap = r_run && (m_cnt == m_per - 1);
      r_load = m_pend && (r_wrap || !r_run);
      r_fin  = 0;
      if (r_run) m_out = (m_cnt >= m_off && m_cnt < m_off + m_dut);
      if (r_load) begin
        dc = (m_dut_s > m_per_s) ? m_per_s : m_dut_s;
        oc = (m_per_s == 0) ? 0 : ((m_off_s > m_per_s - dc) ? m_per_s - dc : m_off_s);
        m_per = m_per_s; m_dut = dc; m_off = oc; m_mode = m_mode_s; m_rpt = m_rpt_s;
        m_cnt = 0;
      end else if (r_wrap) begin
        m_cnt = 0;
        if (m_mode != 0) begin
          if (m_rpt == 0) r_fin = 1; else m_rpt--;
        end
      end else if (r_run) m_cnt++;
      r_com = 0;
      if (wr_en) begin
        case (addr)
          3'd0: begin
            if (wdata[16]) m_en0 = wdata[0];
            if (wdata[17]) m_en1 = wdata[1];
            r_com = wdata[2] && wdata[18];
          end
          3'd1: m_per_s = wdata[7:0];
          3'd2: m_dut_s = wdata[7:0];
          3'd3: m_off_s = wdata[7:0];
          3'd4: begin m_mode_s = wdata[0]; m_rpt_s = wdata[11:8]; end
          3'd5: if (wdata[0]) m_done = 0;
          default: ;
        endcase
      end
      if (r_fin) begin m_en0 = 0; m_done = 1; end
      if (r_com) m_pend = 1; else if (r_load) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({ph, " pwm_o vs model"}, int'(pwm_o), m_out);
      chk({ph, " irq_o vs model"}, int'(irq_o), m_done);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = 32'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 3'(a); #1; v = int'(rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_hi(int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwm_o); end
  endtask

  task automatic setup(int per, int dty, int off, int mode, int rpt);
    wr(0, 32'h0003_0000);
    wr(1, per); wr(2, dty); wr(3, off); wr(4, mode | (rpt << 8));
    wr(0, 32'h0004_0004);
    wr(0, 32'h0003_0003);
  endtask

  int v, h;

  initial begin
    void'($urandom(1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_o after reset", int'(pwm_o), 0);
    chk("R1 irq_o after reset", int'(irq_o), 0);
    rd(0, v); chk("R1 enable reg", v, 0);
    rd(1, v); chk("R1 period reg", v, 0);

    // R8 masked enable writes
    ph = "R8";
    wr(0, 32'h0000_0003); rd(0, v); chk("R8 unmasked write ignored", v & 3, 0);
    wr(0, 32'h0001_0003); rd(0, v); chk("R8 only bit0 set", v & 3, 1);
    wr(0, 32'h0002_0002); rd(0, v); chk("R8 bit1 set", v & 3, 3);
    wr(0, 32'h0001_0000); rd(0, v); chk("R8 bit0 cleared alone", v & 3, 2);
    wr(0, 32'h0003_0000); rd(0, v); chk("R8 both cleared", v & 3, 0);

    // R2 basic waveform
    ph = "R2";
    setup(10, 3, 4, 0, 0); idle(5);
    count_hi(20, h); chk("R2 highs in two periods", h, 6);

    // R3 full and empty duty
    ph = "R3";
    setup(7, 7, 0, 0, 0); idle(3);
    count_hi(14, h); chk("R3 duty==period constant high", h, 14);
    setup(7, 0, 3, 0, 0); idle(3);
    count_hi(14, h); chk("R3 duty 0 constant low", h, 0);

    // R4 clamps
    ph = "R4";
    setup(7, 9, 2, 0, 0); idle(3);
    count_hi(14, h); chk("R4 duty above period clamps high", h, 14);
    setup(10, 3, 9, 0, 0); idle(3);
    count_hi(20, h); chk("R4 offset clamp highs", h, 6);

    // R5 zero period freezes
    ph = "R5";
    setup(0, 5, 3, 0, 0); idle(2);
    v = int'(pwm_o); idle(12);
    chk("R5 zero period holds output", int'(pwm_o), v);

    // R6 staged writes without commit; R7 commit at boundary
    ph = "R6";
    setup(12, 4, 2, 0, 0); idle(4);
    wr(1, 5); wr(2, 1); wr(3, 0);
    count_hi(24, h); chk("R6 uncommitted writes ignored", h, 8);
    ph = "R7";
    wr(0, 32'h0004_0004);
    rd(0, v); chk("R7 pending flag set mid-period", (v >> 2) & 1, 1);
    idle(30);
    rd(0, v); chk("R7 pending flag cleared", (v >> 2) & 1, 0);
    count_hi(10, h); chk("R7 new settings after boundary", h, 2);

    // R9 freeze on disable
    ph = "R9";
    setup(9, 4, 3, 0, 0); idle(6);
    wr(0, 32'h0001_0000); v = int'(pwm_o); idle(12);
    chk("R9 chan disable holds level", int'(pwm_o), v);
    wr(0, 32'h0001_0001); idle(7);
    wr(0, 32'h0002_0000); v = int'(pwm_o); idle(12);
    chk("R9 clock disable holds level", int'(pwm_o), v);
    wr(0, 32'h0002_0002); idle(20);

    // R10 oneshot
    ph = "R10";
    setup(6, 2, 1, 1, 2); idle(10);
    chk("R10 irq low mid-run", int'(irq_o), 0);
    idle(30);
    chk("R10 irq after N+1 periods", int'(irq_o), 1);
    rd(0, v); chk("R10 channel enable cleared", v & 1, 0);
    rd(5, v); chk("R10 status reads flag", v & 1, 1);
    wr(5, 1);
    chk("R10 irq cleared by write", int'(irq_o), 0);

    // R11 continuous
    ph = "R11";
    setup(6, 2, 1, 0, 3); idle(120);
    chk("R11 no irq in continuous", int'(irq_o), 0);

    // random settings, half committed live
    ph = "R2";
    for (int it = 0; it < 60; it++) begin
      int p, d, o;
      p = $urandom % 20; d = $urandom % 24; o = $urandom % 24;
      if (it % 2 == 0) begin
        wr(1, p); wr(2, d); wr(3, o); wr(4, 0); wr(0, 32'h0007_0007);
      end else begin
        setup(p, d, o, 0, 0);
      end
      idle(5 + ($urandom % 40));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule